// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of a three-wire link to a 12-bit differential sampling converter. It drives an active-low chip select and a serial clock derived from the system clock, and it reads the converter's serial data line. In this kind of converter, pulling chip select low both starts a conversion and opens the data transfer. The serial clock also paces the conversion, so the controller keeps chip select low for every clock pulse of the frame.

A one-cycle `start_i` pulse requests one frame. Each frame is 16 serial clock periods long. The first four bits are zero padding. The remaining twelve bits are the result in two's complement, most significant bit first. The controller drops the padding and sign-extends the result to a 16-bit signed word. It presents that word with a one-cycle valid pulse, and it flags a framing error when any padding bit reads as one. After each frame, chip select stays high for a minimum quiet time. A request that arrives while a frame or the quiet time is running is kept and served afterwards.

The control is a state machine with six states:
- `ST_IDLE`: waiting for a request.
- `ST_LEAD`: chip select low, serial clock still high.
- `ST_LOW`: serial clock low.
- `ST_HIGH`: serial clock high.
- `ST_DONE`: result out, chip select released.
- `ST_QUIET`: minimum gap before the next frame.

Its transitions are:
- IDLE→LEAD on a pending request.
- LEAD→LOW after one half period.
- LOW→HIGH after one half period, sampling the data line.
- HIGH→LOW after one half period while bits remain.
- HIGH→DONE after one half period once 16 bits are in.
- DONE→QUIET unconditionally.
- QUIET→IDLE after `QUIET_CYC` cycles.

Top module: `adcrd_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `adc_cs_n_o` is 1, `adc_sclk_o` is 1 and `sample_valid_o` is 0.
- R2: Every frame carries exactly 16 rising edges of `adc_sclk_o` while `adc_cs_n_o` is 0. `adc_sclk_o` is 1 whenever `adc_cs_n_o` is 1.
- R3: Each low phase of `adc_sclk_o` inside a frame lasts exactly `HALF_CYC` system clocks. The data line is sampled on the rising edge of the serial clock; the converter is expected to change it on the falling edge.
- R4: Serial bit k of a frame (k = 0 first) has weight 2^(15-k) in the frame word. The output is bits 11..0 of the frame word, sign-extended from bit 11 to 16 bits.
- R5: `frame_err_o` equals the OR of frame-word bits 15..12 and is updated together with the valid pulse.
- R6: `sample_valid_o` is high for exactly one system clock per frame. This is the first cycle in which `adc_cs_n_o` is back at 1.
- R7: Between the end of one frame and the start of the next, `adc_cs_n_o` stays 1 for at least `QUIET_CYC` system clocks.
- R8: A `start_i` pulse that arrives while a frame or quiet time is running is not lost: it produces one further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one readout frame |
| adc_sdata_i | input | 1 | Serial data from the converter |
| adc_cs_n_o | output | 1 | Active-low chip select / conversion start |
| adc_sclk_o | output | 1 | Serial clock, idles high |
| sample_o | output | 16 | Sign-extended signed result |
| sample_valid_o | output | 1 | One-cycle strobe for `sample_o` |
| frame_err_o | output | 1 | A padding bit read as one |

## Verification
The hardest case to reach is a request that lands while the controller is busy. It must be held through the rest of the frame and the quiet time, and then turned into a second frame with its own data. The bench issues a second start pulse in the middle of a running frame. A converter model loads a fresh frame word at each chip select fall. The scoreboard then expects both results in order, and the gap between the two frames is measured against the quiet minimum. Padding errors are produced by frames whose top nibble is nonzero, with both a positive and a negative result.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_DONE,
        ST_QUIET
    } rd_state_e;
endpackage

// File: rtl/adcrd_clkdiv.sv
// Half-period tick generator for the serial clock.
module adcrd_clkdiv #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == CW'(HALF_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adcrd_shifter.sv
// Collects the frame bits, splits off padding and sign-extends the result.
module adcrd_shifter #(
    parameter int FRAME_BITS = 16,
    parameter int PAD_BITS   = 4,
    parameter int OUT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic             full_o,
    output logic [OUT_W-1:0] value_o,
    output logic             pad_err_o
);
    localparam int DATA_BITS = FRAME_BITS - PAD_BITS;
    localparam int CNT_W     = $clog2(FRAME_BITS + 1);

    logic [FRAME_BITS-1:0] sr_q;
    logic [CNT_W-1:0]      cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (shift_i) begin
            sr_q  <= {sr_q[FRAME_BITS-2:0], bit_i};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign full_o    = (cnt_q == CNT_W'(FRAME_BITS));
    assign pad_err_o = |sr_q[FRAME_BITS-1:DATA_BITS];

    generate
        if (OUT_W > DATA_BITS) begin : g_sext
            assign value_o = {{(OUT_W-DATA_BITS){sr_q[DATA_BITS-1]}}, sr_q[DATA_BITS-1:0]};
        end else begin : g_plain
            assign value_o = sr_q[DATA_BITS-1 -: OUT_W];
        end
    endgenerate

    // R2
    no_extra_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |-> !full_o);
endmodule

// File: rtl/adcrd_ctrl.sv
// Host-side readout controller for a serial sampling converter.
module adcrd_ctrl
    import adcrd_pkg::*;
#(
    parameter int HALF_CYC   = 2,
    parameter int QUIET_CYC  = 5,
    parameter int FRAME_BITS = 16,
    parameter int PAD_BITS   = 4,
    parameter int OUT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             adc_sdata_i,
    output logic             adc_cs_n_o,
    output logic             adc_sclk_o,
    output logic [OUT_W-1:0] sample_o,
    output logic             sample_valid_o,
    output logic             frame_err_o
);
    localparam int QW  = $clog2(QUIET_CYC + 2);
    localparam int EW  = $clog2(FRAME_BITS + 2);

    rd_state_e        state_q, state_nx;
    logic             pend_q;
    logic [QW-1:0]    qcnt_q;
    logic             tick, div_run, shift, full, pad_err;
    logic [OUT_W-1:0] value;

    assign div_run = (state_q == ST_LEAD) || (state_q == ST_LOW) || (state_q == ST_HIGH);
    assign shift   = (state_q == ST_LOW) && tick;

    adcrd_clkdiv #(.HALF_CYC(HALF_CYC)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (div_run),
        .tick_o(tick)
    );

    adcrd_shifter #(
        .FRAME_BITS(FRAME_BITS),
        .PAD_BITS  (PAD_BITS),
        .OUT_W     (OUT_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (state_q == ST_IDLE),
        .shift_i  (shift),
        .bit_i    (adc_sdata_i),
        .full_o   (full),
        .value_o  (value),
        .pad_err_o(pad_err)
    );

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (pend_q) state_nx = ST_LEAD;
            ST_LEAD:  if (tick)   state_nx = ST_LOW;
            ST_LOW:   if (tick)   state_nx = ST_HIGH;
            ST_HIGH:  if (tick)   state_nx = full ? ST_DONE : ST_LOW;
            ST_DONE:              state_nx = ST_QUIET;
            ST_QUIET: if (qcnt_q == QW'(QUIET_CYC - 1)) state_nx = ST_IDLE;
            default:              state_nx = ST_IDLE;
        endcase
    end

    // State register, pending request and quiet counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
            qcnt_q  <= '0;
        end else begin
            state_q <= state_nx;
            pend_q  <= start_i || (pend_q && (state_q != ST_IDLE));
            qcnt_q  <= (state_q == ST_QUIET) ? qcnt_q + 1'b1 : '0;
        end
    end

    // Registered outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_cs_n_o     <= 1'b1;
            adc_sclk_o     <= 1'b1;
            sample_valid_o <= 1'b0;
            sample_o       <= '0;
            frame_err_o    <= 1'b0;
        end else begin
            adc_cs_n_o     <= !((state_nx == ST_LEAD) || (state_nx == ST_LOW) || (state_nx == ST_HIGH));
            adc_sclk_o     <= (state_nx != ST_LOW);
            sample_valid_o <= (state_nx == ST_DONE);
            if (state_nx == ST_DONE) begin
                sample_o    <= value;
                frame_err_o <= pad_err;
            end
        end
    end

    // Checker state: rising edges per frame, high time of chip select
    logic          sclk_d_q;
    logic [EW-1:0] rise_cnt_q;
    logic [QW-1:0] hi_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d_q   <= 1'b1;
            rise_cnt_q <= '0;
            hi_cnt_q   <= QW'(QUIET_CYC + 1);
        end else begin
            sclk_d_q <= adc_sclk_o;
            if (adc_cs_n_o) rise_cnt_q <= '0;
            else if (adc_sclk_o && !sclk_d_q) rise_cnt_q <= rise_cnt_q + 1'b1;
            if (!adc_cs_n_o) hi_cnt_q <= '0;
            else if (hi_cnt_q != QW'(QUIET_CYC + 1)) hi_cnt_q <= hi_cnt_q + 1'b1;
        end
    end

    // R2
    sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n_o |-> adc_sclk_o);

    // R2
    edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n_o) |-> (rise_cnt_q == EW'(FRAME_BITS)));

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_o |=> !sample_valid_o);

    // R6
    valid_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_o |-> (adc_cs_n_o && $rose(adc_cs_n_o)));

    // R7
    quiet_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n_o) |-> (hi_cnt_q >= QW'(QUIET_CYC)));

    // R4
    sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_o |-> (sample_o[OUT_W-1] == sample_o[FRAME_BITS-PAD_BITS-1]));
endmodule

// File: tb/tb_adcrd_ctrl.sv
module tb_adcrd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int QUIET      = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sdata = 1'b0;
    logic        cs_n, sclk, valid, ferr;
    logic [15:0] sample;

    int checks = 0;
    int fails  = 0;
    int sent   = 0;
    int got    = 0;
    bit timeout = 0;

    logic [15:0] slave_q[$];
    logic [16:0] exp_q[$];
    logic [15:0] cur_word = '0;
    int          bit_idx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adcrd_ctrl #(.HALF_CYC(HALF), .QUIET_CYC(QUIET)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .adc_sdata_i   (sdata),
        .adc_cs_n_o    (cs_n),
        .adc_sclk_o    (sclk),
        .sample_o      (sample),
        .sample_valid_o(valid),
        .frame_err_o   (ferr)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Converter model: new word at chip select fall, next bit on each falling serial edge
    always @(negedge cs_n) begin
        cur_word = (slave_q.size() != 0) ? slave_q.pop_front() : 16'h0000;
        bit_idx  = 0;
    end
    always @(negedge sclk) begin
        if (!cs_n && bit_idx < 16) begin
            sdata = cur_word[15 - bit_idx];
            bit_idx++;
        end
    end

    // Driver: queue the frame word and its expected result, then pulse start
    task automatic send(input logic [15:0] w);
        slave_q.push_back(w);
        exp_q.push_back({|w[15:12], {{4{w[11]}}, w[11:0]}});
        sent++;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (QUIET + 4) @(negedge clk);
    endtask

    // Monitor / scoreboard
    logic prev_cs = 1'b1, prev_sclk = 1'b1, prev_valid = 1'b0;
    int   low_len = 0, rises = 0, hi_len = 0;
    bit   seen_frame = 0;
    int   sclk_bad = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n && !sclk) sclk_bad++;
            if (!sclk) low_len++;
            if (!cs_n && sclk && !prev_sclk) begin
                chk(low_len == HALF, "R3", "sclk low phase", low_len, HALF);
                rises++;
                low_len = 0;
            end
            if (cs_n && !prev_cs) begin
                chk(rises == 16, "R2", "rising edges per frame", rises, 16);
                rises  = 0;
                hi_len = 0;
            end
            if (!cs_n && prev_cs) begin
                if (seen_frame) chk(hi_len >= QUIET, "R7", "quiet gap", hi_len, QUIET);
                seen_frame = 1;
                low_len = 0;
            end
            if (cs_n) hi_len++;
            if (valid) begin
                logic [16:0] e;
                got++;
                chk(!prev_valid, "R6", "valid longer than one cycle", 1, 0);
                chk(cs_n && !prev_cs, "R6", "valid not at chip select release", {prev_cs, cs_n}, 2'b01);
                if (exp_q.size() == 0) begin
                    chk(0, "R8", "unexpected result", sample, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(sample == e[15:0], "R4", "sample", sample, e[15:0]);
                    chk(ferr == e[16], "R5", "frame error", ferr, e[16]);
                end
            end
            prev_cs    = cs_n;
            prev_sclk  = sclk;
            prev_valid = valid;
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                // R1: reset state
                chk(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
                chk(sclk == 1'b1, "R1", "sclk in reset", sclk, 1);
                chk(valid == 1'b0, "R1", "valid in reset", valid, 0);
                rst_n = 1'b1;
                @(negedge clk);
                chk(cs_n == 1'b1 && sclk == 1'b1 && valid == 1'b0, "R1", "idle after reset",
                    {cs_n, sclk, valid}, 3'b110);

                // R4: positive, negative and boundary results
                send(16'h07FF); drain();
                send(16'h0800); drain();
                send(16'h0FFF); drain();
                send(16'h0000); drain();
                send(16'h0A5C); drain();
                send(16'h0123); drain();
                // R5: nonzero padding
                send(16'h8123); drain();
                send(16'h1ABC); drain();

                // R8: second request issued in the middle of a running frame
                send(16'h0321);
                repeat (20) @(negedge clk);
                send(16'h0C00);
                drain();

                // R8: request while the quiet gap of the previous frame runs
                send(16'h0456);
                while (!valid) @(negedge clk);
                @(negedge clk);
                send(16'h0B07);
                drain();

                chk(got == sent, "R8", "frames served", got, sent);
                chk(sclk_bad == 0, "R2", "sclk low while deselected", sclk_bad, 0);
            end
            begin
                repeat (50000) @(posedge clk);
                timeout = 1;
            end
        join_any
        disable fork;
        if (timeout) chk(0, "R8", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule